// File: doc/BRIEF.md
# Serial Condition-Code Write Port

This block lets a host controller write an 8-bit condition code into a processing core over a slow serial link. It also decides whether a conditional jump should be taken. The host raises a request line and shifts a command byte and then a data byte on a serial clock and data pin. It then watches a ready output. The data byte is not applied at once: it waits and lands in the condition-code register on the next leading edge of the audio frame clock. Until then, ready stays low and further host writes are refused.

A 9-bit condition vector is formed from the stored code and one hardware condition pin. The vector is compared bit by bit against a 9-bit condition mask that the program loads through a parallel port. The jump output is high whenever the two share a set bit. The mask is cleared only by the hard reset, so it survives a soft reset. All serial and frame inputs are asynchronous and are brought into the system clock domain through multi-stage synchronizers with edge detectors.

Top module: `cond_code_port`

## Requirements
- R1: A write is the command byte 0xC4 followed by one data byte, both sent most significant bit first. Each bit is sampled on a rising edge of `host_sclk` while `host_req` is high.
- R2: The received data byte reaches `cond_code` only on the first leading frame edge after the transfer completes, never at the moment the last serial bit arrives.
- R3: `host_rdy` goes low after the final bit of a valid write. It returns high together with the register update, within two frame periods.
- R4: Any host write started while `host_rdy` is low is ignored as a whole: `cond_code` keeps the value of the earlier write.
- R5: If the first byte is not 0xC4, the rest of the transaction is ignored: `cond_code` is unchanged and `host_rdy` never drops.
- R6: Lowering `host_req` before all 16 bits have arrived aborts the write and discards the partial bits. A following complete write is received correctly.
- R7: The condition vector has `ext_cond` in bit 8 and `cond_code[7:0]` in bits 7..0. `jump_take` is high exactly when some bit is 1 in both this vector and the mask.
- R8: A pulse on `mask_load` stores `mask_din` as the mask. The mask is cleared by `rst_n` and is kept through a soft reset.
- R9: A falling `soft_rst_n` clears `cond_code` to zero, aborts any write in progress and leaves `host_rdy` high.
- R10: With `frame_inv` = 0 the leading frame edge is the rising edge of `frame_clk`; with `frame_inv` = 1 it is the falling edge.
- R11: After `rst_n`, `cond_code` is 0, the mask is 0, `host_rdy` is 1 and `jump_take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst_n | input | 1 | Soft reset, active low, synchronous to clk |
| host_sclk | input | 1 | Serial bit clock from the host |
| host_sdi | input | 1 | Serial data from the host |
| host_req | input | 1 | Transaction frame from the host, high during a write |
| host_rdy | output | 1 | High when a new write may be started |
| frame_clk | input | 1 | Audio frame clock |
| frame_inv | input | 1 | Selects the falling frame edge as the leading edge |
| ext_cond | input | 1 | Hardware condition pin, bit 8 of the condition vector |
| mask_load | input | 1 | Load strobe for the condition mask |
| mask_din | input | 9 | New condition mask value |
| cond_code | output | 8 | Current condition-code register |
| jump_take | output | 1 | High when the condition vector and the mask overlap |

## Verification
The assertions assume that `host_sclk`, `host_sdi`, `host_req` and `frame_clk` change slowly compared with `clk`. Each level must be held for more than the synchronizer depth plus one cycle, so that no edge is lost and data is stable when its clock edge is seen. The bench holds every serial level for four system cycles and uses a frame period of 200 cycles. It raises the request several cycles before the first bit and drops it only after the last bit. In the busy-write scenario, the bench starts the second write just after a frame edge, so that the refused transfer falls well inside the busy window.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
   localparam int unsigned CMD_BITS  = 8;
   localparam int unsigned CODE_BITS = 8;
   localparam logic [CMD_BITS-1:0] CMD_COND_WRITE = 8'hC4;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1
   } edge_sel_e;
endpackage

// File: rtl/ccp_sync.sv
module ccp_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ccp_sync needs at least two stages");
   end

   logic [W-1:0] st [STAGES];
   logic [W-1:0] prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= st[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= st[STAGES-1];
   end

   assign q    = st[STAGES-1];
   assign rise = st[STAGES-1] & ~prev;
   assign fall = ~st[STAGES-1] & prev;
endmodule

// File: rtl/ccp_rx.sv
module ccp_rx #(
   parameter int unsigned CMD_W   = 8,
   parameter int unsigned DATA_W  = 8,
   parameter logic [CMD_W-1:0] CMD_VAL = 8'hC4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              req,
   input  logic              bit_stb,
   input  logic              sdi,
   input  logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] data
);
   localparam int unsigned TOT   = CMD_W + DATA_W;
   localparam int unsigned CNT_W = $clog2(TOT + 1);

   logic [TOT-1:0]   sh;
   logic [TOT-1:0]   nxt;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_n;
   logic             skip;

   assign nxt   = {sh[TOT-2:0], sdi};
   assign cnt_n = cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         skip <= 1'b0;
         done <= 1'b0;
         data <= '0;
      end else begin
         done <= 1'b0;
         if (!req) begin
            cnt  <= '0;
            skip <= 1'b0;
         end else if (clr) begin
            cnt  <= '0;
            skip <= 1'b1;
         end else if (bit_stb && !skip) begin
            if (busy) begin
               skip <= 1'b1;
            end else begin
               sh  <= nxt;
               cnt <= cnt_n;
               if (cnt_n == CNT_W'(CMD_W) && nxt[CMD_W-1:0] != CMD_VAL)
                  skip <= 1'b1;
               if (cnt_n == CNT_W'(TOT)) begin
                  done <= 1'b1;
                  data <= nxt[DATA_W-1:0];
                  skip <= 1'b1;
               end
            end
         end
      end
   end

   // R4
   busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);
endmodule

// File: rtl/ccp_commit.sv
module ccp_commit #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              done,
   input  logic [DATA_W-1:0] din,
   input  logic              lead,
   output logic [DATA_W-1:0] code_q,
   output logic              rdy
);
   logic [DATA_W-1:0] hold;
   logic              pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold    <= '0;
         pending <= 1'b0;
         code_q  <= '0;
      end else if (clr) begin
         pending <= 1'b0;
         code_q  <= '0;
      end else if (done) begin
         hold    <= din;
         pending <= 1'b1;
      end else if (pending && lead) begin
         code_q  <= hold;
         pending <= 1'b0;
      end
   end

   assign rdy = !pending;

   // R2
   code_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lead && !clr) |=> $stable(code_q));
   // R3
   rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy) |-> $past(done));
   // R3
   rdy_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy && lead && !done) |=> rdy);
endmodule

// File: rtl/cond_code_port.sv
module cond_code_port
   import ccp_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CMD_W       = CMD_BITS,
   parameter int unsigned CODE_W      = CODE_BITS,
   parameter logic [CMD_W-1:0] CMD_VAL = CMD_COND_WRITE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_n,
   input  logic              host_sclk,
   input  logic              host_sdi,
   input  logic              host_req,
   output logic              host_rdy,
   input  logic              frame_clk,
   input  logic              frame_inv,
   input  logic              ext_cond,
   input  logic              mask_load,
   input  logic [CODE_W:0]   mask_din,
   output logic [CODE_W-1:0] cond_code,
   output logic              jump_take
);
   localparam int unsigned VEC_W = CODE_W + 1;
   localparam int unsigned IN_W  = 4;

   if (CODE_W < 1 || CMD_W < 2) begin : g_bad_width
      $error("cond_code_port widths too small");
   end

   logic [IN_W-1:0]   s_q, s_rise, s_fall;
   logic              soft_q, soft_clr;
   logic              lead;
   logic              rx_done;
   logic [CODE_W-1:0] rx_data;
   logic [VEC_W-1:0]  mask_q;
   logic [VEC_W-1:0]  cond_vec;
   edge_sel_e         esel;

   ccp_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({frame_clk, host_req, host_sclk, host_sdi}),
      .q    (s_q),
      .rise (s_rise),
      .fall (s_fall)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_q <= 1'b1;
      else        soft_q <= soft_rst_n;
   end
   assign soft_clr = soft_q && !soft_rst_n;

   assign esel = frame_inv ? EDGE_FALL : EDGE_RISE;
   assign lead = (esel == EDGE_FALL) ? s_fall[3] : s_rise[3];

   ccp_rx #(.CMD_W(CMD_W), .DATA_W(CODE_W), .CMD_VAL(CMD_VAL)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (soft_clr),
      .req    (s_q[2]),
      .bit_stb(s_rise[1]),
      .sdi    (s_q[0]),
      .busy   (!host_rdy),
      .done   (rx_done),
      .data   (rx_data)
   );

   ccp_commit #(.DATA_W(CODE_W)) u_commit (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_clr),
      .done  (rx_done),
      .din   (rx_data),
      .lead  (lead),
      .code_q(cond_code),
      .rdy   (host_rdy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_load) mask_q <= mask_din;
   end

   assign cond_vec  = {ext_cond, cond_code};
   assign jump_take = |(cond_vec & mask_q);

   // R8
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_load |=> $stable(mask_q));
   // R7
   no_mask_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !jump_take);
endmodule

// File: tb/cond_code_port_test.sv
module cond_code_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst_n = 1'b1;
   logic       host_sclk = 1'b0;
   logic       host_sdi = 1'b0;
   logic       host_req = 1'b0;
   logic       host_rdy;
   logic       frame_clk = 1'b0;
   logic       frame_inv = 1'b0;
   logic       ext_cond = 1'b0;
   logic       mask_load = 1'b0;
   logic [8:0] mask_din = '0;
   logic [7:0] cond_code;
   logic       jump_take;

   int errors = 0;
   int checks = 0;

   logic       rdy_low_seen = 1'b0;
   logic       rdy_prev = 1'b1;
   logic [7:0] code_at_fall = '0;
   logic [7:0] code_prev = '0;
   logic       frame_at_change = 1'b0;

   cond_code_port uut (
      .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
      .host_sclk(host_sclk), .host_sdi(host_sdi), .host_req(host_req),
      .host_rdy(host_rdy), .frame_clk(frame_clk), .frame_inv(frame_inv),
      .ext_cond(ext_cond), .mask_load(mask_load), .mask_din(mask_din),
      .cond_code(cond_code), .jump_take(jump_take)
   );

   always #4 clk = ~clk;
   initial begin
      #3;
      forever #800 frame_clk = ~frame_clk;
   end

   always @(negedge clk) begin
      if (!host_rdy) rdy_low_seen <= 1'b1;
      if (rdy_prev && !host_rdy) code_at_fall <= cond_code;
      if (cond_code != code_prev) frame_at_change <= frame_clk;
      rdy_prev  <= host_rdy;
      code_prev <= cond_code;
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [15:0] w, input int nbits);
      host_req = 1'b1;
      cyc(4);
      for (int i = 0; i < nbits; i++) begin
         host_sdi = w[15-i];
         cyc(4);
         host_sclk = 1'b1;
         cyc(4);
         host_sclk = 1'b0;
      end
      cyc(4);
      host_req = 1'b0;
      cyc(4);
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!(host_rdy && rdy_low_seen) && n < 450) begin
         cyc(1);
         n++;
      end
   endtask

   task automatic write_ok(input logic [7:0] d, input logic [7:0] old, input string tag);
      int n;
      rdy_low_seen = 1'b0;
      send({8'hC4, d}, 16);
      wait_ready(n);
      cyc(2);
      check({tag, " rdy dropped"}, 16'(rdy_low_seen), 16'd1);
      check({tag, " code held until frame edge"}, 16'(code_at_fall), 16'(old));
      check({tag, " rdy back within two frames"}, 16'(n < 400), 16'd1);
      check({tag, " code written"}, 16'(cond_code), 16'(d));
   endtask

   task automatic load_mask(input logic [8:0] m);
      mask_din = m;
      mask_load = 1'b1;
      cyc(1);
      mask_load = 1'b0;
      cyc(1);
   endtask

   task automatic t_reset;
      check("R11 code after reset", 16'(cond_code), 16'h00);
      check("R11 rdy after reset", 16'(host_rdy), 16'd1);
      check("R11 jump after reset", 16'(jump_take), 16'd0);
      ext_cond = 1'b1;
      cyc(1);
      check("R11 mask zero after reset (jump with pin high)", 16'(jump_take), 16'd0);
      ext_cond = 1'b0;
   endtask

   task automatic t_basic;
      write_ok(8'h5A, 8'h00, "R1 R2 R3 first");
      write_ok(8'hA3, 8'h5A, "R1 R2 R3 second");
      check("R10 rising edge used", 16'(frame_at_change), 16'd1);
   endtask

   task automatic t_inverted;
      frame_inv = 1'b1;
      cyc(2);
      write_ok(8'h3C, 8'hA3, "R10 inverted");
      check("R10 falling edge used", 16'(frame_at_change), 16'd0);
      frame_inv = 1'b0;
      cyc(2);
   endtask

   task automatic t_busy;
      int n;
      @(posedge frame_clk);
      cyc(1);
      rdy_low_seen = 1'b0;
      send({8'hC4, 8'h81}, 16);
      send({8'hC4, 8'h7E}, 16);
      wait_ready(n);
      cyc(450);
      check("R4 busy write ignored", 16'(cond_code), 16'h81);
      check("R4 rdy high after", 16'(host_rdy), 16'd1);
   endtask

   task automatic t_badcmd;
      rdy_low_seen = 1'b0;
      send({8'hA5, 8'h11}, 16);
      cyc(450);
      check("R5 code unchanged", 16'(cond_code), 16'h81);
      check("R5 rdy never dropped", 16'(rdy_low_seen), 16'd0);
   endtask

   task automatic t_abort;
      rdy_low_seen = 1'b0;
      send({8'hC4, 8'h96}, 12);
      cyc(450);
      check("R6 aborted write no update", 16'(cond_code), 16'h81);
      check("R6 aborted write rdy kept", 16'(rdy_low_seen), 16'd0);
      send({8'hC4, 8'h00}, 5);
      write_ok(8'h24, 8'h81, "R6 after abort");
   endtask

   task automatic t_jump;
      load_mask(9'h003);
      check("R7 no overlap", 16'(jump_take), 16'd0);
      load_mask(9'h004);
      check("R7 code bit 2 overlap", 16'(jump_take), 16'd1);
      load_mask(9'h020);
      check("R7 code bit 5 overlap", 16'(jump_take), 16'd1);
      load_mask(9'h100);
      check("R7 pin low no jump", 16'(jump_take), 16'd0);
      ext_cond = 1'b1;
      cyc(1);
      check("R7 pin bit 8 jump", 16'(jump_take), 16'd1);
      load_mask(9'h000);
      check("R7 empty mask", 16'(jump_take), 16'd0);
      ext_cond = 1'b0;
   endtask

   task automatic t_soft;
      load_mask(9'h100);
      soft_rst_n = 1'b0;
      cyc(3);
      soft_rst_n = 1'b1;
      cyc(2);
      check("R9 code cleared", 16'(cond_code), 16'h00);
      check("R9 rdy high", 16'(host_rdy), 16'd1);
      ext_cond = 1'b1;
      cyc(1);
      check("R8 mask survives soft reset", 16'(jump_take), 16'd1);
      rst_n = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      cyc(2);
      check("R8 mask cleared by hard reset", 16'(jump_take), 16'd0);
      ext_cond = 1'b0;
   endtask

   initial begin
      cyc(5);
      rst_n = 1'b1;
      cyc(5);
      t_reset();
      t_basic();
      t_inverted();
      t_busy();
      t_badcmd();
      t_abort();
      t_jump();
      t_soft();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule